// File: doc/BRIEF.md
# Six-Mode Programmable Interval Counter

This block is one programmable down-counter channel with a counting clock, a gate input and a single waveform output. A host programs it through a narrow byte-wide write port. A two-bit address picks either a data port or the control port. A control byte picks the operating mode and how the count value is assembled from bytes. Data bytes then supply the starting count, which is 16 bits at the default parameters. The counter decrements once per clock, and the output is shaped according to the mode.

The six modes cover the usual timing jobs. There is an interrupt raised at terminal count, a retriggerable one-shot started by the gate, a periodic single-clock rate pulse, a square wave with automatic reload, and two single-clock strobes. One strobe is started by software and the other by a gate edge. Only the first channel exists. Addresses for the other two channels are decoded, but writes to them change nothing. Counting is binary only.

Top module: `interval_counter`

## Requirements
- R1: After reset the output is high and no counting takes place.
- R2: A write to address 3 whose bits 7:6 are 00, whose bits 5:4 are nonzero and whose bit 0 is 0 is a control word. Bits 3:1 give the mode, and codes 6 and 7 act as modes 2 and 3. Such a write stops counting, drives the output low for mode 0 and high for every other mode, and restarts byte assembly.
- R3: Several writes are ignored and leave the output and mode unchanged. These are data writes to addresses 1 and 2, and control writes whose bits 7:6 are nonzero. Control writes with bits 5:4 equal to 00 or with bit 0 set are ignored in the same way.
- R4: The load format is set by bits 5:4. With 01 a single data byte at address 0 is the low byte and the high byte is zero. With 10 a single byte is the high byte and the low byte is zero. With 11 two writes supply the low byte and then the high byte. The count loads with the last byte written.
- R5: Mode 0 works as follows. With count N loaded at clock edge E, the output is low from E onward and goes high at edge E+N. It then stays high until a new control word is written.
- R6: Mode 1 works as follows. Loading keeps the output high. A gate rising edge sampled at edge T drives the output low until edge T+N, where it returns high. A new rising edge during the pulse restarts the full length.
- R7: Mode 2 works as follows. After a load at edge E, the output is low for exactly one clock starting at edge E+N-1. It then repeats every N clocks from the stored count (N of at least 2).
- R8: Mode 3 gives a square wave of period N after a load. The output is high for the first ceil(N/2) clocks of each period and low for the remaining floor(N/2) clocks (N of at least 2).
- R9: Mode 4 works as follows. After a load at edge E, the output is high except for one clock from edge E+N. No further strobe comes without a new count.
- R10: Mode 5 works as follows. A load only arms the channel. A gate rising edge sampled at edge T drives the output low for one clock starting at edge T+N.
- R11: Gate low halts counting in modes 0, 2, 3 and 4. In modes 2 and 3 it also forces the output high on the next edge, and a later gate rising edge reloads the stored count.
- R12: A count value of zero behaves as 65536 clocks at the default width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the byte port |
| addr | input | 2 | Port select: 0 to 2 data, 3 control |
| wdata | input | BUS_W | Write data byte |
| gate | input | 1 | Gate input, level and rising-edge sensitive |
| tmr_out | output | 1 | Waveform output |

## Verification
The bench builds the block with its default byte width of 8, which gives a 16-bit count. At this width a written zero means a 65536-clock wait, and a full run of that length still fits inside the run budget. The same width also makes the high-byte-only and two-byte formats produce counts of 256 and 258. These values are short enough to time exactly, yet large enough to show that the upper byte takes part in the count.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

  typedef enum logic [2:0] {
    M_TC      = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE    = 3'd2,
    M_SQUARE  = 3'd3,
    M_SWSTB   = 3'd4,
    M_HWSTB   = 3'd5
  } mode_e;

  typedef enum logic [1:0] {
    F_LATCH = 2'd0,
    F_LO    = 2'd1,
    F_HI    = 2'd2,
    F_LOHI  = 2'd3
  } fmt_e;

  localparam logic [1:0] ADDR_CTL = 2'b11;
  localparam logic [1:0] ADDR_CH0 = 2'b00;

  // codes 6 and 7 alias onto the periodic modes
  function automatic mode_e decode_mode(input logic [2:0] code);
    if (code[1]) return mode_e'({1'b0, code[1:0]});
    return mode_e'(code);
  endfunction

endpackage

// File: rtl/ivc_loader.sv
module ivc_loader
  import ivc_pkg::*;
#(
  parameter int BUS_W = 8,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  output logic             ctl_wr,
  output mode_e            ctl_mode,
  output mode_e            mode_q,
  output logic             load_now,
  output logic [CNT_W-1:0] load_val
);

  fmt_e             fmt_q;
  logic             hi_next;
  logic [BUS_W-1:0] lo_hold;
  logic             data_wr;

  assign ctl_wr  = wr_en && (addr == ADDR_CTL) && (wdata[7:6] == 2'b00)
                   && (wdata[5:4] != 2'b00) && !wdata[0];
  assign ctl_mode = decode_mode(wdata[3:1]);
  assign data_wr  = wr_en && (addr == ADDR_CH0);

  always_comb begin
    load_now = 1'b0;
    load_val = '0;
    if (data_wr) begin
      unique case (fmt_q)
        F_LO:    begin load_now = 1'b1; load_val = {{BUS_W{1'b0}}, wdata}; end
        F_HI:    begin load_now = 1'b1; load_val = {wdata, {BUS_W{1'b0}}}; end
        F_LOHI:  begin load_now = hi_next; load_val = {wdata, lo_hold}; end
        default: begin load_now = 1'b0; load_val = '0; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_q   <= F_LO;
      mode_q  <= M_TC;
      hi_next <= 1'b0;
      lo_hold <= '0;
    end else if (ctl_wr) begin
      fmt_q   <= fmt_e'(wdata[5:4]);
      mode_q  <= ctl_mode;
      hi_next <= 1'b0;
    end else if (data_wr && fmt_q == F_LOHI) begin
      hi_next <= !hi_next;
      if (!hi_next) lo_hold <= wdata;
    end
  end

endmodule

// File: rtl/ivc_core.sv
module ivc_core
  import ivc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate,
  input  logic             ctl_wr,
  input  mode_e            ctl_mode,
  input  mode_e            mode_q,
  input  logic             load_now,
  input  logic [CNT_W-1:0] load_val,
  output logic             out_q,
  output logic             gate_rise
);

  logic [CNT_W-1:0] cnt, reload, sq_next;
  logic             run, armed, gate_q;

  // zero stands for the full range 2**CNT_W
  function automatic logic [CNT_W:0] widen(input logic [CNT_W-1:0] v);
    return {(v == '0), v};
  endfunction

  // square wave: high while the remaining count exceeds half the period
  function automatic logic sq_high(input logic [CNT_W-1:0] c,
                                   input logic [CNT_W-1:0] n);
    return widen(c) > (widen(n) >> 1);
  endfunction

  assign gate_rise = gate && !gate_q;
  assign sq_next   = (cnt == CNT_W'(1)) ? reload : cnt - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      reload <= '0;
      run    <= 1'b0;
      armed  <= 1'b0;
      out_q  <= 1'b1;
      gate_q <= 1'b0;
    end else begin
      gate_q <= gate;
      if (ctl_wr) begin
        run   <= 1'b0;
        armed <= 1'b0;
        out_q <= (ctl_mode != M_TC);
      end else if (load_now) begin
        reload <= load_val;
        armed  <= 1'b1;
        unique case (mode_q)
          M_TC:              begin cnt <= load_val; run <= 1'b1; out_q <= 1'b0; end
          M_ONESHOT, M_HWSTB: begin run <= 1'b0; out_q <= 1'b1; end
          default:           begin cnt <= load_val; run <= 1'b1; out_q <= 1'b1; end
        endcase
      end else begin
        unique case (mode_q)
          M_TC: begin
            if (run && gate) begin
              cnt <= cnt - 1'b1;
              if (cnt == CNT_W'(1)) begin out_q <= 1'b1; run <= 1'b0; end
            end
          end
          M_ONESHOT: begin
            if (gate_rise && armed) begin
              cnt <= reload; run <= 1'b1; out_q <= 1'b0;
            end else if (run) begin
              cnt <= cnt - 1'b1;
              if (cnt == CNT_W'(1)) begin out_q <= 1'b1; run <= 1'b0; end
            end
          end
          M_RATE: begin
            if (!gate) out_q <= 1'b1;
            else if (gate_rise && run) begin cnt <= reload; out_q <= 1'b1; end
            else if (run) begin
              if (cnt == CNT_W'(1)) begin cnt <= reload; out_q <= 1'b1; end
              else begin cnt <= cnt - 1'b1; out_q <= (cnt != CNT_W'(2)); end
            end
          end
          M_SQUARE: begin
            if (!gate) out_q <= 1'b1;
            else if (gate_rise && run) begin cnt <= reload; out_q <= 1'b1; end
            else if (run) begin cnt <= sq_next; out_q <= sq_high(sq_next, reload); end
          end
          M_SWSTB: begin
            if (!out_q) out_q <= 1'b1;
            else if (run && gate) begin
              cnt <= cnt - 1'b1;
              if (cnt == CNT_W'(1)) begin out_q <= 1'b0; run <= 1'b0; end
            end
          end
          default: begin
            if (gate_rise && armed) begin cnt <= reload; run <= 1'b1; out_q <= 1'b1; end
            else if (!out_q) out_q <= 1'b1;
            else if (run) begin
              cnt <= cnt - 1'b1;
              if (cnt == CNT_W'(1)) begin out_q <= 1'b0; run <= 1'b0; end
            end
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/interval_counter.sv
module interval_counter
  import ivc_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  input  logic             gate,
  output logic             tmr_out
);

  localparam int CNT_W = 2 * BUS_W;

  logic             ctl_wr;
  mode_e            ctl_mode;
  mode_e            mode_q;
  logic             load_now;
  logic [CNT_W-1:0] load_val;
  logic             gate_rise;

  ivc_loader #(.BUS_W(BUS_W)) u_loader (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .ctl_wr   (ctl_wr),
    .ctl_mode (ctl_mode),
    .mode_q   (mode_q),
    .load_now (load_now),
    .load_val (load_val)
  );

  ivc_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate      (gate),
    .ctl_wr    (ctl_wr),
    .ctl_mode  (ctl_mode),
    .mode_q    (mode_q),
    .load_now  (load_now),
    .load_val  (load_val),
    .out_q     (tmr_out),
    .gate_rise (gate_rise)
  );

endmodule

// File: rtl/ivc_checker.sv
module ivc_checker #(
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [BUS_W-1:0] wdata,
  input logic             gate,
  input logic             tmr_out,
  input logic             ctl_wr,
  input logic             load_now,
  input logic [2:0]       mode_q
);

  // R2: a control word sets the output level on the next edge
  a_r2_ctl_level: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (tmr_out == ($past(wdata[3:1]) != 3'd0)));

  // R3: control bytes aimed at another channel leave the mode alone
  a_r3_other_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'b11 && wdata[7:6] != 2'b00) |=> $stable(mode_q));

  // R5: terminal-count output stays high until reprogrammed
  a_r5_tc_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd0 && tmr_out && !ctl_wr && !load_now) |=> tmr_out);

  // R7: rate pulse lasts one clock
  a_r7_one_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd2 && !tmr_out && !ctl_wr) |=> tmr_out);

  // R9, R10: strobes last one clock
  a_r9_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == 3'd4 || mode_q == 3'd5) && !tmr_out && !ctl_wr) |=> tmr_out);

  // R11: gate low forces the periodic output high
  a_r11_gate_forces_high: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == 3'd2 || mode_q == 3'd3) && !gate && !ctl_wr) |=> tmr_out);

endmodule

bind interval_counter ivc_checker #(.BUS_W(BUS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .addr     (addr),
  .wdata    (wdata),
  .gate     (gate),
  .tmr_out  (tmr_out),
  .ctl_wr   (ctl_wr),
  .load_now (load_now),
  .mode_q   (mode_q)
);

// File: tb/interval_counter_tb.sv
`timescale 1ns/1ps
module interval_counter_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic       gate = 1'b1;
  logic       tmr_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  interval_counter #(.BUS_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .gate(gate), .tmr_out(tmr_out)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: out=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic exp_rate(input int k, input int n);
    return (k % n) != (n - 1);
  endfunction

  function automatic logic exp_square(input int k, input int n);
    int rem;
    rem = n - (k % n);
    return (2 * rem) > n;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; gate = 1'b1;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 reset level", tmr_out, 1'b1);
    step(4);
    chk("R1 idle after reset", tmr_out, 1'b1);
  endtask

  task automatic t_mode0();
    gate = 1'b1;
    wr(2'd3, 8'h10);
    chk("R2 mode0 control low", tmr_out, 1'b0);
    wr(2'd0, 8'd5);
    for (int k = 0; k <= 7; k++) begin
      chk("R5 terminal count", tmr_out, (k >= 5));
      step(1);
    end
  endtask

  task automatic t_ctl_stops();
    wr(2'd3, 8'h10);
    wr(2'd0, 8'd3);
    step(1);
    wr(2'd3, 8'h10);
    chk("R2 control restarts low", tmr_out, 1'b0);
    step(6);
    chk("R2 control halts count", tmr_out, 1'b0);
    wr(2'd3, 8'h14);
    chk("R2 nonzero mode high", tmr_out, 1'b1);
  endtask

  task automatic t_ignored();
    wr(2'd3, 8'h10);
    wr(2'd0, 8'd2);
    step(3);
    chk("R3 setup high", tmr_out, 1'b1);
    wr(2'd3, 8'h50); chk("R3 select 1 ignored", tmr_out, 1'b1);
    wr(2'd3, 8'hD0); chk("R3 select 3 ignored", tmr_out, 1'b1);
    wr(2'd3, 8'h00); chk("R3 format 00 ignored", tmr_out, 1'b1);
    wr(2'd3, 8'h11); chk("R3 bit0 ignored", tmr_out, 1'b1);
    wr(2'd1, 8'd5);  chk("R3 address 1 ignored", tmr_out, 1'b1);
    wr(2'd2, 8'd5);  chk("R3 address 2 ignored", tmr_out, 1'b1);
    step(8);
    chk("R3 still high", tmr_out, 1'b1);
  endtask

  task automatic t_formats();
    wr(2'd3, 8'h30);
    wr(2'd0, 8'h02);
    wr(2'd0, 8'h01);
    step(257); chk("R4 two-byte 258 early", tmr_out, 1'b0);
    step(1);   chk("R4 two-byte 258 done", tmr_out, 1'b1);
    wr(2'd3, 8'h20);
    wr(2'd0, 8'h01);
    step(255); chk("R4 high-only 256 early", tmr_out, 1'b0);
    step(1);   chk("R4 high-only 256 done", tmr_out, 1'b1);
  endtask

  task automatic t_mode1();
    gate = 1'b0;
    wr(2'd3, 8'h12);
    wr(2'd0, 8'd3);
    chk("R6 armed high", tmr_out, 1'b1);
    gate = 1'b1;
    step(1); chk("R6 trigger low", tmr_out, 1'b0);
    gate = 1'b0;
    step(1); chk("R6 pulse k1", tmr_out, 1'b0);
    gate = 1'b1;
    step(1); chk("R6 retrigger", tmr_out, 1'b0);
    step(2); chk("R6 extended", tmr_out, 1'b0);
    step(1); chk("R6 pulse end", tmr_out, 1'b1);
    gate = 1'b1;
  endtask

  task automatic t_mode2(input logic [7:0] ctl, input int n, input string req);
    gate = 1'b1;
    wr(2'd3, ctl);
    wr(2'd0, 8'(n));
    for (int k = 0; k <= 2 * n + 1; k++) begin
      chk(req, tmr_out, exp_rate(k, n));
      step(1);
    end
  endtask

  task automatic t_mode3(input int n);
    gate = 1'b1;
    wr(2'd3, 8'h16);
    wr(2'd0, 8'(n));
    for (int k = 0; k <= 3 * n; k++) begin
      chk("R8 square wave", tmr_out, exp_square(k, n));
      step(1);
    end
  endtask

  task automatic t_mode4();
    gate = 1'b1;
    wr(2'd3, 8'h18);
    wr(2'd0, 8'd3);
    for (int k = 0; k <= 8; k++) begin
      chk("R9 software strobe", tmr_out, (k != 3));
      step(1);
    end
  endtask

  task automatic t_mode5();
    gate = 1'b0;
    wr(2'd3, 8'h1A);
    wr(2'd0, 8'd2);
    step(3);
    chk("R10 waits for gate", tmr_out, 1'b1);
    gate = 1'b1;
    step(1);
    for (int k = 0; k <= 5; k++) begin
      chk("R10 gate strobe", tmr_out, (k != 2));
      step(1);
    end
  endtask

  task automatic t_gate();
    gate = 1'b0;
    wr(2'd3, 8'h10);
    wr(2'd0, 8'd3);
    step(5); chk("R11 mode0 halted", tmr_out, 1'b0);
    gate = 1'b1;
    step(2); chk("R11 mode0 resume", tmr_out, 1'b0);
    step(1); chk("R11 mode0 finish", tmr_out, 1'b1);
    wr(2'd3, 8'h14);
    wr(2'd0, 8'd4);
    step(2);
    gate = 1'b0;
    step(1); chk("R11 rate forced high", tmr_out, 1'b1);
    step(2); chk("R11 rate held", tmr_out, 1'b1);
    gate = 1'b1;
    step(1); chk("R11 rate reload", tmr_out, 1'b1);
    step(2); chk("R11 rate after reload", tmr_out, 1'b1);
    step(1); chk("R11 rate pulse", tmr_out, 1'b0);
    step(1); chk("R11 rate pulse end", tmr_out, 1'b1);
    wr(2'd3, 8'h16);
    wr(2'd0, 8'd4);
    step(2);
    chk("R11 square low phase", tmr_out, 1'b0);
    gate = 1'b0;
    step(1); chk("R11 square forced high", tmr_out, 1'b1);
    gate = 1'b1;
  endtask

  task automatic t_zero();
    gate = 1'b1;
    wr(2'd3, 8'h10);
    wr(2'd0, 8'd0);
    step(65535); chk("R12 zero count early", tmr_out, 1'b0);
    step(1);     chk("R12 zero count done", tmr_out, 1'b1);
  endtask

  initial begin
    t_reset();
    t_mode0();
    t_ctl_stops();
    t_ignored();
    t_formats();
    t_mode1();
    t_mode2(8'h14, 4, "R7 rate pulse");
    t_mode2(8'h1C, 3, "R2 R7 code 6 alias");
    t_mode3(5);
    t_mode3(4);
    t_mode4();
    t_mode5();
    t_gate();
    t_zero();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule